// File: doc/BRIEF.md
# Single-Cycle Three-Instruction Processor Core

This block is a small processor core in which every instruction starts and finishes inside one clock period, from one rising edge to the next. It understands three operations taken from a classic 32-bit load/store instruction set: a register-to-register add, a word load, and a compare-equal branch. Every other encoding is a no-op that only advances the program counter. The program counter, a branch-pending register and a 32-entry register file are the only state, and all of it changes on the rising clock edge.

Instruction and data memories sit outside the core and are read combinationally. The core drives a byte address, and each memory ignores address bits [1:0] and returns the addressed 32-bit word in the same cycle. Branches follow a delayed rule: the word after a branch always executes, and a taken branch redirects only the fetch after that word. A trace port reports the program counter and, in the same cycle, any register write the current instruction makes. A surrounding test environment can therefore follow execution without looking inside the core.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and drops any pending branch target, so the first fetch after reset is at 0 and the second is at 4, even if reset arrived while a taken branch was executing.
- R2: A word whose bits [31:26] are 000000, bits [10:6] are 00000 and bits [5:0] are 100000 is an add. It writes the sum of the registers named in bits [25:21] and bits [20:16] into the register named in bits [15:11]. Example: 0x012A4020 puts register 9 plus register 10 into register 8.
- R3: Opcode 100011 is a word load. Its byte address, driven on `dmem_addr`, is the value of the register in bits [25:21] plus the sign-extended 16-bit field in bits [15:0]. It writes the returned word into the register named in bits [20:16].
- R4: Loads have no delay: the instruction right after a load reads the loaded value.
- R5: Opcode 000100 is a branch that compares the registers in bits [25:21] and bits [20:16]. When they are equal, the target is the branch's own address plus 4 plus four times the sign-extended 16-bit field. When they differ, execution continues in sequence.
- R6: The word after a branch always executes, whether or not the branch is taken. A taken target is fetched in the cycle after that word. Without a pending target, the next address is the current one plus 4.
- R7: Register 0 reads as zero in every operand position, and writes aimed at it are dropped.
- R8: Any other opcode, and opcode 000000 with a different function or shift field, changes no register and moves the program counter on by 4.
- R9: `imem_addr` and `pc_o` carry the address of the executing instruction. `trace_we` is high exactly when the instruction writes a nonzero register. In that cycle `trace_reg` and `trace_data` give the register number and the value it receives.
- R10: A branch placed in the delay slot of a taken branch still executes. The first target runs as that branch's delay slot, and the second branch's target follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Byte address of the load being executed |
| dmem_rdata | input | 32 | Data word returned combinationally |
| pc_o | output | 32 | Program counter of the executing instruction |
| trace_we | output | 1 | The current instruction writes a nonzero register |
| trace_reg | output | 5 | Destination register number of that write |
| trace_data | output | 32 | Value written to the destination register |

## Verification
The bench runs a program that covers untaken and taken branches, a backward branch onto itself, and a branch sitting in another branch's delay slot. A core that squashed the slot would lose the register write of the slot instruction. A core that applied the target one cycle early would skip that instruction. A core that misordered a double branch would leave the trace off its expected sequence of addresses. Other cases check a load whose result is used at once (a delayed load would feed a stale sum), a negative load offset (a zero-extended one would read far outside the data), and writes to register 0 (a core that kept them would report a write and later read a nonzero operand). Two decoys check the no-op rule: an add-like word with a different function code, whose wrong write shows up in a later sum, and an unknown opcode. A reset during a taken branch checks that the pending target does not survive.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN     = 32;
    localparam int NUM_REGS = 32;
    localparam int REG_AW   = $clog2(NUM_REGS);
    localparam int IMM_W    = 16;

    localparam logic [5:0] OPC_SPECIAL = 6'b000000;
    localparam logic [5:0] OPC_BEQ     = 6'b000100;
    localparam logic [5:0] OPC_LW      = 6'b100011;
    localparam logic [5:0] FN_ADD      = 6'b100000;

    typedef enum logic [1:0] {
        K_NOP,
        K_ADD,
        K_LW,
        K_BEQ
    } kind_e;

    typedef struct packed {
        logic [5:0]        op;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [4:0]        sa;
        logic [5:0]        fn;
    } iword_t;

    typedef struct packed {
        kind_e             kind;
        logic              wr_en;
        logic [REG_AW-1:0] wr_idx;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output ctrl_t             ctrl,
    output logic [REG_AW-1:0] rs_idx,
    output logic [REG_AW-1:0] rt_idx,
    output logic [XLEN-1:0]   imm_ext
);
    iword_t f;

    always_comb begin
        f       = iword_t'(instr);
        rs_idx  = f.rs;
        rt_idx  = f.rt;
        imm_ext = sext_imm(instr[IMM_W-1:0]);

        ctrl.kind   = K_NOP;
        ctrl.wr_idx = '0;
        if (f.op == OPC_SPECIAL && f.fn == FN_ADD && f.sa == 5'd0) begin
            ctrl.kind   = K_ADD;
            ctrl.wr_idx = f.rd;
        end else if (f.op == OPC_LW) begin
            ctrl.kind   = K_LW;
            ctrl.wr_idx = f.rt;
        end else if (f.op == OPC_BEQ) begin
            ctrl.kind   = K_BEQ;
        end
        ctrl.wr_en = (ctrl.kind == K_ADD || ctrl.kind == K_LW) && (ctrl.wr_idx != '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int DEPTH = NUM_REGS,
    parameter int WIDTH = XLEN,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic [AW-1:0]    ra_idx,
    input  logic [AW-1:0]    rb_idx,
    output logic [WIDTH-1:0] ra_data,
    output logic [WIDTH-1:0] rb_data,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);
    logic [WIDTH-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
    assign rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];
endmodule

// File: rtl/sc_pc_unit.sv
module sc_pc_unit
    import sc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take_branch,
    input  logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_plus4,
    output logic            pend_valid,
    output logic [XLEN-1:0] pend_target
);
    logic [XLEN-1:0] next_pc;

    assign pc_plus4 = pc + XLEN'(4);
    assign next_pc  = pend_valid ? pend_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc          <= RESET_PC;
            pend_valid  <= 1'b0;
            pend_target <= '0;
        end else begin
            pc          <= next_pc;
            pend_valid  <= take_branch;
            pend_target <= br_target;
        end
    end
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [XLEN-1:0]   imem_rdata,
    output logic [XLEN-1:0]   dmem_addr,
    input  logic [XLEN-1:0]   dmem_rdata,
    output logic [XLEN-1:0]   pc_o,
    output logic              trace_we,
    output logic [REG_AW-1:0] trace_reg,
    output logic [XLEN-1:0]   trace_data
);
    ctrl_t             ctrl;
    logic [REG_AW-1:0] rs_idx, rt_idx;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   rs_val, rt_val;
    logic [XLEN-1:0]   pc, pc_plus4, br_target, pend_target, wb_data;
    logic              pend_valid, rs_eq, take_branch;

    sc_decode u_dec (
        .instr   (imem_rdata),
        .ctrl    (ctrl),
        .rs_idx  (rs_idx),
        .rt_idx  (rt_idx),
        .imm_ext (imm_ext)
    );

    sc_regfile #(.DEPTH(NUM_REGS), .WIDTH(XLEN)) u_rf (
        .clk     (clk),
        .ra_idx  (rs_idx),
        .rb_idx  (rt_idx),
        .ra_data (rs_val),
        .rb_data (rt_val),
        .we      (ctrl.wr_en),
        .wa      (ctrl.wr_idx),
        .wd      (wb_data)
    );

    assign rs_eq       = (rs_val == rt_val);
    assign take_branch = (ctrl.kind == K_BEQ) && rs_eq;
    assign br_target   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};

    sc_pc_unit #(.RESET_PC(RESET_PC)) u_pc (
        .clk         (clk),
        .rst         (rst),
        .take_branch (take_branch),
        .br_target   (br_target),
        .pc          (pc),
        .pc_plus4    (pc_plus4),
        .pend_valid  (pend_valid),
        .pend_target (pend_target)
    );

    assign dmem_addr = rs_val + imm_ext;
    assign wb_data   = (ctrl.kind == K_LW) ? dmem_rdata : (rs_val + rt_val);

    assign imem_addr  = pc;
    assign pc_o       = pc;
    assign trace_we   = ctrl.wr_en;
    assign trace_reg  = ctrl.wr_idx;
    assign trace_data = wb_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc_o,
    input logic [5:0]        chk_op,
    input logic [5:0]        chk_fn,
    input logic [REG_AW-1:0] chk_rt,
    input logic [XLEN-1:0]   dmem_rdata,
    input logic              trace_we,
    input logic [REG_AW-1:0] trace_reg,
    input logic [XLEN-1:0]   trace_data,
    input logic              pend_valid,
    input logic [XLEN-1:0]   pend_target,
    input logic              rs_eq
);
    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && !pend_valid)); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !pend_valid |=> pc_o == $past(pc_o) + XLEN'(4)); // R6

    AST_PEND_FETCH: assert property (@(posedge clk) disable iff (rst)
        pend_valid |=> pc_o == $past(pend_target)); // R6

    AST_BEQ_ARMS: assert property (@(posedge clk) disable iff (rst)
        (chk_op == OPC_BEQ && rs_eq) |=> pend_valid); // R5

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        trace_we |-> trace_reg != '0); // R7

    AST_LW_WRITE: assert property (@(posedge clk) disable iff (rst)
        (chk_op == OPC_LW && chk_rt != '0) |-> (trace_we && trace_data == dmem_rdata)); // R3

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((chk_op != OPC_SPECIAL && chk_op != OPC_LW && chk_op != OPC_BEQ)
         || (chk_op == OPC_SPECIAL && chk_fn != FN_ADD)) |-> !trace_we); // R8
endmodule

bind sc_core sc_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_o        (pc_o),
    .chk_op      (imem_rdata[31:26]),
    .chk_fn      (imem_rdata[5:0]),
    .chk_rt      (imem_rdata[20:16]),
    .dmem_rdata  (dmem_rdata),
    .trace_we    (trace_we),
    .trace_reg   (trace_reg),
    .trace_data  (trace_data),
    .pend_valid  (pend_valid),
    .pend_target (pend_target),
    .rs_eq       (rs_eq)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
    localparam int CLK_PERIOD = 10;
    localparam int N_EXP      = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, pc_o, trace_data;
    logic        trace_we;
    logic [4:0]  trace_reg;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    sc_core u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .pc_o       (pc_o),
        .trace_we   (trace_we),
        .trace_reg  (trace_reg),
        .trace_data (trace_data)
    );

    function automatic logic [31:0] enc_add(input logic [4:0] rd, rs, rt);
        return {6'b000000, rs, rt, rd, 5'd0, 6'b100000};
    endfunction
    function automatic logic [31:0] enc_lw(input logic [4:0] rt, rs, input logic [15:0] off);
        return {6'b100011, rs, rt, off};
    endfunction
    function automatic logic [31:0] enc_beq(input logic [4:0] rs, rt, input logic [15:0] off);
        return {6'b000100, rs, rt, off};
    endfunction

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {requirement, pc, write enable, destination, value}
    localparam logic [73:0] EXP [N_EXP] = '{
        {4'd3,  32'h00, 1'b1, 5'd1,  32'd5},
        {4'd3,  32'h04, 1'b1, 5'd2,  32'd7},
        {4'd4,  32'h08, 1'b1, 5'd3,  32'd12},
        {4'd5,  32'h0C, 1'b0, 5'd0,  32'd0},
        {4'd2,  32'h10, 1'b1, 5'd4,  32'd17},
        {4'd3,  32'h14, 1'b1, 5'd5,  32'hFFFFFFFF},
        {4'd5,  32'h18, 1'b0, 5'd0,  32'd0},
        {4'd6,  32'h1C, 1'b1, 5'd6,  32'd4},
        {4'd7,  32'h28, 1'b0, 5'd0,  32'd0},
        {4'd7,  32'h2C, 1'b1, 5'd8,  32'd5},
        {4'd8,  32'h30, 1'b0, 5'd0,  32'd0},
        {4'd8,  32'h34, 1'b0, 5'd0,  32'd0},
        {4'd3,  32'h38, 1'b1, 5'd9,  32'h10},
        {4'd8,  32'h3C, 1'b1, 5'd10, 32'h21},
        {4'd10, 32'h40, 1'b0, 5'd0,  32'd0},
        {4'd10, 32'h44, 1'b0, 5'd0,  32'd0},
        {4'd10, 32'h4C, 1'b1, 5'd12, 32'd10},
        {4'd10, 32'h58, 1'b1, 5'd13, 32'd22},
        {4'd5,  32'h5C, 1'b0, 5'd0,  32'd0},
        {4'd6,  32'h60, 1'b1, 5'd14, 32'd44},
        {4'd5,  32'h5C, 1'b0, 5'd0,  32'd0},
        {4'd6,  32'h60, 1'b1, 5'd14, 32'd44}
    };

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'hDEAD0000 + i;
        end
        dmem[0] = 32'd5;
        dmem[1] = 32'd7;
        dmem[2] = 32'h10;
        dmem[3] = 32'hFFFFFFFF;

        imem[0]  = enc_lw(5'd1, 5'd0, 16'd0);
        imem[1]  = enc_lw(5'd2, 5'd0, 16'd4);
        imem[2]  = enc_add(5'd3, 5'd1, 5'd2);
        imem[3]  = enc_beq(5'd1, 5'd2, 16'd10);
        imem[4]  = enc_add(5'd4, 5'd3, 5'd1);
        imem[5]  = enc_lw(5'd5, 5'd0, 16'd12);
        imem[6]  = enc_beq(5'd1, 5'd1, 16'd3);
        imem[7]  = enc_add(5'd6, 5'd5, 5'd1);
        imem[8]  = enc_add(5'd7, 5'd1, 5'd1);
        imem[9]  = enc_add(5'd7, 5'd2, 5'd2);
        imem[10] = enc_add(5'd0, 5'd1, 5'd2);
        imem[11] = enc_add(5'd8, 5'd0, 5'd1);
        imem[12] = 32'hFC22_4020;
        imem[13] = {6'b000000, 5'd1, 5'd2, 5'd4, 5'd0, 6'b100010};
        imem[14] = enc_lw(5'd9, 5'd3, 16'hFFFC);
        imem[15] = enc_add(5'd10, 5'd9, 5'd4);
        imem[16] = enc_beq(5'd0, 5'd0, 16'd2);
        imem[17] = enc_beq(5'd1, 5'd1, 16'd4);
        imem[18] = enc_add(5'd15, 5'd1, 5'd1);
        imem[19] = enc_add(5'd12, 5'd1, 5'd1);
        imem[22] = enc_add(5'd13, 5'd12, 5'd3);
        imem[23] = enc_beq(5'd0, 5'd0, 16'hFFFF);
        imem[24] = enc_add(5'd14, 5'd13, 5'd13);

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc_o == 32'h0, "R1 pc in reset", pc_o, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < N_EXP; i++) begin
            #1;
            check(pc_o == EXP[i][69:38], req_name(EXP[i][73:70]), pc_o, EXP[i][69:38]);
            check(imem_addr == pc_o, "R9 fetch address", imem_addr, pc_o);
            check(trace_we == EXP[i][37], req_name(EXP[i][73:70]), {31'd0, trace_we}, {31'd0, EXP[i][37]});
            if (EXP[i][37]) begin
                check(trace_reg == EXP[i][36:32], "R9 trace register", {27'd0, trace_reg}, {27'd0, EXP[i][36:32]});
                check(trace_data == EXP[i][31:0], req_name(EXP[i][73:70]), trace_data, EXP[i][31:0]);
            end
            if (EXP[i][69:38] == 32'h38) begin
                check(dmem_addr == 32'h8, "R3 negative offset address", dmem_addr, 32'h8);
            end
            @(negedge clk);
        end

        // reset while a taken branch is executing: its target must not survive
        #1;
        check(pc_o == 32'h5C, "R5 self loop branch", pc_o, 32'h5C);
        rst = 1'b1;
        @(negedge clk);
        check(pc_o == 32'h0, "R1 pc after reset", pc_o, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(pc_o == 32'h4, "R1 pending cleared", pc_o, 32'h4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule